// File: doc/BRIEF.md
# Network Controller Register Bank with Interrupt Masking

This block holds the control and status words of a network controller behind a simple 32-bit, word-addressed read/write bus. Each word carries four fixed per-bit access masks. Read-only bits ignore writes. Write-1-to-clear bits are set by hardware events and cleared by software. Write-only bits always read back as zero. The interrupt status word clears itself when it is read. The datapath blocks raise event pulses that set status bits. Software sees those bits through the bus and through a single level interrupt line.

The interrupt section has four words. A status word latches events. A mask word starts with every source masked. Two write-only strobe words edit the mask: the enable word clears the mask bits written as 1, and the disable word sets them. A table of destination-address slots is also held here. Writing the low word of a slot takes the slot out of service. Writing the high word puts it back into service. The controller's receive filter reads the slot contents and their in-service flags.

All accesses take one cycle. Read data is combinational from the current state. Every side effect (a store, a clear-on-read, a mask edit) happens at the next rising clock edge.

Top module: `nic_csr_bank`

Word map (word index):
- 0: control
- 1: transmit status
- 2: receive status
- 3: interrupt status
- 4: interrupt enable
- 5: interrupt disable
- 6: interrupt mask
- 7: receive queue base
- 8: transmit queue base
- 16 + 2n: low word of slot n
- 17 + 2n: high word of slot n

## Requirements
- R1: After reset, every word reads zero except the interrupt mask, which reads 0x07FFFFFF. The interrupt line is low and no address slot is in service.
- R2: Writes to read-only bits are ignored. The low two bits of both queue base words always read 0. Control bits 31..19 always read 0.
- R3: In the transmit status word, bits in mask 0x1F7 are set by `evt_tx` pulses. A written 1 clears such a bit and a written 0 leaves it unchanged. No other bit of that word is ever set. The receive status word behaves the same way with mask 0xF and `evt_rx`.
- R4: Write-only bits read back as 0. These are the whole enable and disable words, and control bits 0x00073E60. The written control bits still appear on `ctrl_q`.
- R5: A write to the enable word clears the written bits in the mask. A write to the disable word sets them.
- R6: An `evt_irq` bit sets its interrupt status bit only when the matching mask bit is 0.
- R7: `irq` rises one cycle after an unmasked event. A read of the status word returns its value, and then the word clears and `irq` falls at the next edge.
- R8: An unmasked event that arrives in the same cycle as a status read is kept. It is not lost to the clear.
- R9: When a hardware set and a software write-1-to-clear hit the same status bit in the same cycle, the set wins.
- R10: Writing the low word of slot n takes slot n out of service. Writing its high word puts it in service. The high word holds 16 bits, and its upper bits read 0.
- R11: Reads of unmapped word indices return 0. Writes to them change no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word index of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| evt_irq | input | NUM_IRQ | Interrupt source event pulses |
| evt_tx | input | 32 | Transmit status set pulses |
| evt_rx | input | 32 | Receive status set pulses |
| ctrl_q | output | 32 | Stored control word, including command bits |
| rxq_base | output | 32 | Receive queue base |
| txq_base | output | 32 | Transmit queue base |
| sa_addr | output | NUM_SA*48 | Slot addresses, slot n in bits 48n+47..48n |
| sa_active | output | NUM_SA | In-service flag per slot |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: a 6-bit word index, 27 interrupt sources and 4 address slots. With 27 sources, the mask reset value 0x07FFFFFF can be checked directly, and the top bits of the enable and disable words can be shown to have no effect. With four slots, both the first slot and the last slot are reachable, and so is an unmapped index between the queue bases and the slot table. The same-cycle cases are driven on purpose: a set colliding with a clear, and an event arriving during a status read.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;

    typedef logic [31:0] word_t;

    localparam int unsigned IDX_CTRL  = 0;
    localparam int unsigned IDX_TXST  = 1;
    localparam int unsigned IDX_RXST  = 2;
    localparam int unsigned IDX_ISR   = 3;
    localparam int unsigned IDX_IEN   = 4;
    localparam int unsigned IDX_IDIS  = 5;
    localparam int unsigned IDX_IMASK = 6;
    localparam int unsigned IDX_RXQ   = 7;
    localparam int unsigned IDX_TXQ   = 8;
    localparam int unsigned IDX_SA0   = 16;

    localparam word_t CTRL_RO  = 32'hFFF8_0000;
    localparam word_t CTRL_WO  = 32'h0007_3E60;
    localparam word_t TXST_RO  = 32'hFFFF_FE08;
    localparam word_t TXST_W1C = 32'h0000_01F7;
    localparam word_t RXST_RO  = 32'hFFFF_FFF0;
    localparam word_t RXST_W1C = 32'h0000_000F;
    localparam word_t QB_RO    = 32'h0000_0003;

    typedef struct packed {
        logic ctrl;
        logic txst;
        logic rxst;
        logic isr;
        logic ien;
        logic idis;
        logic imask;
        logic rxq;
        logic txq;
    } csr_sel_t;

    function automatic csr_sel_t decode_idx(input int unsigned idx);
        csr_sel_t s;
        s       = '0;
        s.ctrl  = (idx == IDX_CTRL);
        s.txst  = (idx == IDX_TXST);
        s.rxst  = (idx == IDX_RXST);
        s.isr   = (idx == IDX_ISR);
        s.ien   = (idx == IDX_IEN);
        s.idis  = (idx == IDX_IDIS);
        s.imask = (idx == IDX_IMASK);
        s.rxq   = (idx == IDX_RXQ);
        s.txq   = (idx == IDX_TXQ);
        return s;
    endfunction

    // Merge a bus write into a stored word under its access masks.
    function automatic word_t merge_write(input word_t old, input word_t wd,
                                          input word_t ro, input word_t w1c);
        word_t keep;
        word_t nv;
        keep = ro | w1c;
        nv   = ((wd & ~ro) & ~keep) | (old & keep);
        nv   = nv & ~(w1c & wd);
        return nv;
    endfunction

endpackage

// File: rtl/nic_csr_word.sv
module nic_csr_word
    import nic_csr_pkg::*;
#(
    parameter word_t RESET_VAL = '0,
    parameter word_t RO_MASK   = '0,
    parameter word_t W1C_MASK  = '0,
    parameter word_t WO_MASK   = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  word_t wdata,
    input  word_t hw_set,
    output word_t q,
    output word_t rd_view
);

    word_t nxt;

    always_comb begin
        nxt = wr_en ? merge_write(q, wdata, RO_MASK, W1C_MASK) : q;
        // Hardware sets land after the clear, so they win a collision.
        nxt = nxt | (hw_set & W1C_MASK);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= RESET_VAL;
        else     q <= nxt;
    end

    assign rd_view = q & ~WO_MASK;

endmodule

// File: rtl/nic_irq_ctrl.sv
module nic_irq_ctrl #(
    parameter int NIRQ = 27
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en_wr,
    input  logic            dis_wr,
    input  logic [NIRQ-1:0] wdata,
    input  logic            isr_rd,
    input  logic [NIRQ-1:0] evt,
    output logic [NIRQ-1:0] isr_q,
    output logic [NIRQ-1:0] mask_q,
    output logic            irq
);

    logic [NIRQ-1:0] isr_nxt;
    logic [NIRQ-1:0] mask_nxt;

    always_comb begin
        isr_nxt  = (isr_rd ? '0 : isr_q) | (evt & ~mask_q);
        mask_nxt = mask_q;
        if (en_wr)  mask_nxt = mask_nxt & ~wdata;
        if (dis_wr) mask_nxt = mask_nxt | wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q  <= '0;
            mask_q <= '1;
            irq    <= 1'b0;
        end else begin
            isr_q  <= isr_nxt;
            mask_q <= mask_nxt;
            irq    <= |isr_nxt;
        end
    end

endmodule

// File: rtl/nic_sa_table.sv
module nic_sa_table #(
    parameter int ADDR_W  = 6,
    parameter int NUM_SA  = 4,
    parameter int SA_BASE = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   idx,
    input  logic [31:0]         wdata,
    output logic [NUM_SA*48-1:0] sa_addr,
    output logic [NUM_SA-1:0]   sa_active,
    output logic                hit,
    output logic [31:0]         rd_data
);

    logic [NUM_SA-1:0]       lo_hit;
    logic [NUM_SA-1:0]       hi_hit;
    logic [NUM_SA-1:0][31:0] lo_v;
    logic [NUM_SA-1:0][15:0] hi_v;

    for (genvar n = 0; n < NUM_SA; n++) begin : g_slot
        logic [31:0] lo_q;
        logic [15:0] hi_q;
        logic        act_q;

        assign lo_hit[n] = (idx == ADDR_W'(SA_BASE + 2*n));
        assign hi_hit[n] = (idx == ADDR_W'(SA_BASE + 2*n + 1));

        always_ff @(posedge clk) begin
            if (rst) begin
                lo_q  <= '0;
                hi_q  <= '0;
                act_q <= 1'b0;
            end else if (wr_en && lo_hit[n]) begin
                lo_q  <= wdata;
                act_q <= 1'b0;
            end else if (wr_en && hi_hit[n]) begin
                hi_q  <= wdata[15:0];
                act_q <= 1'b1;
            end
        end

        assign lo_v[n]               = lo_q;
        assign hi_v[n]               = hi_q;
        assign sa_active[n]          = act_q;
        assign sa_addr[48*n +: 48]   = {hi_q, lo_q};
    end

    always_comb begin
        rd_data = '0;
        for (int n = 0; n < NUM_SA; n++) begin
            if (lo_hit[n]) rd_data = rd_data | lo_v[n];
            if (hi_hit[n]) rd_data = rd_data | {16'h0, hi_v[n]};
        end
    end

    assign hit = (|lo_hit) | (|hi_hit);

endmodule

// File: rtl/nic_csr_bank.sv
module nic_csr_bank
    import nic_csr_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int NUM_IRQ = 27,
    parameter int NUM_SA  = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_IRQ-1:0]   evt_irq,
    input  logic [31:0]          evt_tx,
    input  logic [31:0]          evt_rx,
    output logic [31:0]          ctrl_q,
    output logic [31:0]          rxq_base,
    output logic [31:0]          txq_base,
    output logic [NUM_SA*48-1:0] sa_addr,
    output logic [NUM_SA-1:0]    sa_active,
    output logic                 irq
);

    csr_sel_t            sel;
    word_t               ctrl_rd, txst_q, txst_rd, rxst_q, rxst_rd;
    word_t               rxq_rd, txq_rd, sa_rd;
    logic                sa_hit;
    logic [NUM_IRQ-1:0]  isr_q;
    logic [NUM_IRQ-1:0]  mask_q;

    assign sel = decode_idx(32'(bus_addr));

    nic_csr_word #(.RESET_VAL('0), .RO_MASK(CTRL_RO), .W1C_MASK('0), .WO_MASK(CTRL_WO))
    u_ctrl (.clk(clk), .rst(rst), .wr_en(bus_wr && sel.ctrl), .wdata(bus_wdata),
            .hw_set('0), .q(ctrl_q), .rd_view(ctrl_rd));

    nic_csr_word #(.RESET_VAL('0), .RO_MASK(TXST_RO), .W1C_MASK(TXST_W1C), .WO_MASK('0))
    u_txst (.clk(clk), .rst(rst), .wr_en(bus_wr && sel.txst), .wdata(bus_wdata),
            .hw_set(evt_tx), .q(txst_q), .rd_view(txst_rd));

    nic_csr_word #(.RESET_VAL('0), .RO_MASK(RXST_RO), .W1C_MASK(RXST_W1C), .WO_MASK('0))
    u_rxst (.clk(clk), .rst(rst), .wr_en(bus_wr && sel.rxst), .wdata(bus_wdata),
            .hw_set(evt_rx), .q(rxst_q), .rd_view(rxst_rd));

    nic_csr_word #(.RESET_VAL('0), .RO_MASK(QB_RO), .W1C_MASK('0), .WO_MASK('0))
    u_rxq (.clk(clk), .rst(rst), .wr_en(bus_wr && sel.rxq), .wdata(bus_wdata),
           .hw_set('0), .q(rxq_base), .rd_view(rxq_rd));

    nic_csr_word #(.RESET_VAL('0), .RO_MASK(QB_RO), .W1C_MASK('0), .WO_MASK('0))
    u_txq (.clk(clk), .rst(rst), .wr_en(bus_wr && sel.txq), .wdata(bus_wdata),
           .hw_set('0), .q(txq_base), .rd_view(txq_rd));

    nic_irq_ctrl #(.NIRQ(NUM_IRQ)) u_irq (
        .clk(clk), .rst(rst),
        .en_wr(bus_wr && sel.ien), .dis_wr(bus_wr && sel.idis),
        .wdata(bus_wdata[NUM_IRQ-1:0]),
        .isr_rd(bus_rd && sel.isr),
        .evt(evt_irq),
        .isr_q(isr_q), .mask_q(mask_q), .irq(irq)
    );

    nic_sa_table #(.ADDR_W(ADDR_W), .NUM_SA(NUM_SA), .SA_BASE(IDX_SA0)) u_sa (
        .clk(clk), .rst(rst), .wr_en(bus_wr), .idx(bus_addr), .wdata(bus_wdata),
        .sa_addr(sa_addr), .sa_active(sa_active), .hit(sa_hit), .rd_data(sa_rd)
    );

    // Enable and disable words are write-only: they never drive read data.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique0 case (1'b1)
                sel.ctrl:  bus_rdata = ctrl_rd;
                sel.txst:  bus_rdata = txst_rd;
                sel.rxst:  bus_rdata = rxst_rd;
                sel.isr:   bus_rdata = 32'(isr_q);
                sel.imask: bus_rdata = 32'(mask_q);
                sel.rxq:   bus_rdata = rxq_rd;
                sel.txq:   bus_rdata = txq_rd;
                sa_hit:    bus_rdata = sa_rd;
                default:   bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/nic_csr_bank_chk.sv
module nic_csr_bank_chk
    import nic_csr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NIRQ   = 27,
    parameter int NUM_SA = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [31:0]       bus_wdata,
    input logic [NIRQ-1:0]   evt_irq,
    input logic [31:0]       evt_tx,
    input logic [NIRQ-1:0]   isr,
    input logic [NIRQ-1:0]   mask,
    input logic              irq,
    input logic [31:0]       txst,
    input logic [NUM_SA-1:0] sa_active
);

    p_ien_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(IDX_IEN)) |=>
            ((mask & $past(bus_wdata[NIRQ-1:0])) == '0));

    p_idis_sets_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(IDX_IDIS)) |=>
            ((mask & $past(bus_wdata[NIRQ-1:0])) == $past(bus_wdata[NIRQ-1:0])));

    p_masked_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((isr & ~$past(isr) & $past(mask)) == '0));

    p_read_keeps_new_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_W'(IDX_ISR)) |=>
            (isr == $past(evt_irq & ~mask)));

    p_irq_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_W'(IDX_ISR) && (evt_irq & ~mask) == '0) |=> !irq);

    p_w1c_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(IDX_TXST) && evt_tx == '0) |=>
            ((txst & $past(bus_wdata) & TXST_W1C) == '0));

    p_slot_on_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(IDX_SA0 + 1)) |=> sa_active[0]);

    p_slot_off_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(IDX_SA0)) |=> !sa_active[0]);

endmodule

bind nic_csr_bank nic_csr_bank_chk #(.ADDR_W(ADDR_W), .NIRQ(NUM_IRQ), .NUM_SA(NUM_SA)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .evt_irq(evt_irq), .evt_tx(evt_tx),
    .isr(isr_q), .mask(mask_q), .irq(irq), .txst(txst_q), .sa_active(sa_active)
);

// File: tb/sim_nic_csr_bank.sv
module sim_nic_csr_bank;

    localparam int ADDR_W  = 6;
    localparam int NUM_IRQ = 27;
    localparam int NUM_SA  = 4;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [ADDR_W-1:0]    bus_addr = '0;
    logic                 bus_wr = 1'b0;
    logic                 bus_rd = 1'b0;
    logic [31:0]          bus_wdata = '0;
    logic [31:0]          bus_rdata;
    logic [NUM_IRQ-1:0]   evt_irq = '0;
    logic [31:0]          evt_tx = '0;
    logic [31:0]          evt_rx = '0;
    logic [31:0]          ctrl_q, rxq_base, txq_base;
    logic [NUM_SA*48-1:0] sa_addr;
    logic [NUM_SA-1:0]    sa_active;
    logic                 irq;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    nic_csr_bank #(.ADDR_W(ADDR_W), .NUM_IRQ(NUM_IRQ), .NUM_SA(NUM_SA)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_irq(evt_irq),
        .evt_tx(evt_tx), .evt_rx(evt_rx), .ctrl_q(ctrl_q), .rxq_base(rxq_base),
        .txq_base(txq_base), .sa_addr(sa_addr), .sa_active(sa_active), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
        end
    endtask

    task automatic idle();
        bus_wr = 1'b0; bus_rd = 1'b0; evt_irq = '0; evt_tx = '0; evt_rx = '0;
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        bus_addr = ADDR_W'(idx); bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
        @(negedge clk);
        idle();
    endtask

    task automatic rd(input int idx, output logic [31:0] d);
        @(negedge clk);
        bus_addr = ADDR_W'(idx); bus_rd = 1'b1; bus_wr = 1'b0;
        #2 d = bus_rdata;
        @(negedge clk);
        idle();
    endtask

    task automatic pulse(input logic [NUM_IRQ-1:0] ei, input logic [31:0] et,
                         input logic [31:0] er);
        @(negedge clk);
        evt_irq = ei; evt_tx = et; evt_rx = er;
        @(negedge clk);
        idle();
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(0, d);  check("R1 ctrl", d, 0);
        rd(1, d);  check("R1 txst", d, 0);
        rd(3, d);  check("R1 isr", d, 0);
        rd(6, d);  check("R1 mask", d, 32'h07FF_FFFF);
        check("R1 irq", irq, 0);
        check("R1 sa_active", sa_active, 0);
    endtask

    task automatic t_readonly();
        logic [31:0] d;
        wr(7, 32'hFFFF_FFFF); rd(7, d); check("R2 rxq base", d, 32'hFFFF_FFFC);
        wr(8, 32'h1234_5677); rd(8, d); check("R2 txq base", d, 32'h1234_5674);
        check("R2 txq port", txq_base, 32'h1234_5674);
        wr(0, 32'hFFFF_FFFF); rd(0, d);
        check("R2 R4 ctrl readback", d, 32'h0000_C19F);
        check("R4 ctrl port keeps command bits", ctrl_q, 32'h0007_FFFF);
        wr(0, 32'h0);
    endtask

    task automatic t_mask_edit();
        logic [31:0] d;
        wr(4, 32'h0000_0005); rd(4, d); check("R4 enable word reads 0", d, 0);
        rd(6, d); check("R5 enable clears mask", d, 32'h07FF_FFFA);
        wr(5, 32'h0000_0001); rd(5, d); check("R4 disable word reads 0", d, 0);
        rd(6, d); check("R5 disable sets mask", d, 32'h07FF_FFFB);
        wr(5, 32'hFFFF_FFFF); rd(6, d); check("R5 mask width", d, 32'h07FF_FFFF);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        pulse('0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        rd(1, d); check("R3 tx set only in mask", d, 32'h0000_01F7);
        rd(2, d); check("R3 rx set only in mask", d, 32'h0000_000F);
        wr(1, 32'h0); rd(1, d); check("R3 zero leaves bits", d, 32'h0000_01F7);
        wr(1, 32'h5); rd(1, d); check("R3 one clears bits", d, 32'h0000_01F2);
        wr(2, 32'hF); rd(2, d); check("R3 rx clear", d, 0);
        @(negedge clk);
        bus_addr = ADDR_W'(1); bus_wdata = 32'h3; bus_wr = 1'b1; evt_tx = 32'h1;
        @(negedge clk);
        idle();
        rd(1, d); check("R9 set beats clear", d, 32'h0000_01F1);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        pulse(NUM_IRQ'(32'h8), '0, '0);
        rd(3, d); check("R6 masked event ignored", d, 0);
        check("R6 irq stays low", irq, 0);
        wr(4, 32'h18);
        pulse(NUM_IRQ'(32'h10), '0, '0);
        #1 check("R7 irq rises", irq, 1);
        @(negedge clk);
        bus_addr = ADDR_W'(3); bus_rd = 1'b1; evt_irq = NUM_IRQ'(32'h8);
        #2 d = bus_rdata;
        @(negedge clk);
        idle();
        check("R7 read returns status", d, 32'h10);
        #1 check("R8 irq held by new event", irq, 1);
        rd(3, d); check("R8 event during read kept", d, 32'h8);
        #1 check("R7 irq falls after read", irq, 0);
        rd(3, d); check("R7 status cleared", d, 0);
    endtask

    task automatic t_slots();
        logic [31:0] d;
        wr(16, 32'h1122_3344); check("R10 low write leaves inactive", sa_active[0], 0);
        wr(17, 32'hFFFF_AABB); check("R10 high write activates", sa_active[0], 1);
        check("R10 slot0 address", sa_addr[47:0], 48'hAABB_1122_3344);
        rd(17, d); check("R10 high readback", d, 32'h0000_AABB);
        wr(23, 32'h0000_0102); check("R10 slot3 active", sa_active, 4'b1001);
        wr(16, 32'h5566_7788); check("R10 low write deactivates", sa_active, 4'b1000);
        rd(22, d); check("R10 slot3 low", d, 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(63, 32'hFFFF_FFFF); wr(10, 32'hFFFF_FFFF);
        rd(63, d); check("R11 unmapped high reads 0", d, 0);
        rd(10, d); check("R11 unmapped gap reads 0", d, 0);
        rd(0, d);  check("R11 ctrl untouched", d, 0);
        rd(7, d);  check("R11 rxq untouched", d, 32'hFFFF_FFFC);
        check("R11 slots untouched", sa_active, 4'b1000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_readonly();
        t_mask_edit();
        t_w1c();
        t_irq();
        t_slots();
        t_unmapped();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2_000_000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule